// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Driver

This block drives a multiplexed dot-matrix panel with 48 segment lines and up to 32 common lines. The picture comes from a small dual-port display RAM, 4 bits per word. Software writes the RAM through a simple write port. The scanner reads one common's worth of segment bits from the RAM while the previous common is on screen. It then shows that data for a fixed number of scan ticks before moving on.

No pin is driven with a voltage. Each COM and SEG pin gets a 3-bit code that names one rung of an external bias ladder, where 0 is the bottom rung and the top rung is 5 or 7 depending on the bias mode. Drive polarity reverses on every frame, so the panel never sees a net DC component. A frame always lasts 512 scan ticks, whatever the common count; with a 32.768 kHz tick this gives 64 frames per second.

The common count and the ladder size are sampled at frame starts. A blanking input turns every pixel off without disturbing the scan position.

Top module: `lcd_scan`

## Requirements
- R1: During reset, and from reset release until the first common boundary, every COM pin carries the negative-frame non-select code and every SEG pin carries the negative-frame off code. The first common boundary comes after 16 ticks in 32-common mode and after 32 ticks in 16-common mode. The mode in force at that point is the one sampled during reset.
- R2: After that, commons are selected one at a time in ascending index order, with exactly one COM pin at the select code. Each common lasts 512 divided by the common count in ticks (16 or 32), so a frame lasts 512 ticks.
- R3: Codes are ladder indices with top T (5 or 7). In a positive frame: COM select = T, COM non-select = 1, SEG on = 0, SEG off = 2. In a negative frame: COM select = 0, COM non-select = T-1, SEG on = T, SEG off = T-2. Every SEG pin always carries the on or off code of the current frame.
- R4: The first frame after reset is positive, and polarity reverses at every frame start and at no other time.
- R5: While common r is selected, SEG s is on exactly when bit (s mod 4) of RAM word r*12 + s/4 is 1.
- R6: With duty_full = 0, only commons 0 to 15 are scanned, and COM 16 to 31 stay at the non-select code.
- R7: With bias_hi = 1 the top code T is 7; with bias_hi = 0 it is 5.
- R8: A change on duty_full or bias_hi takes effect at the next frame start and never within a frame.
- R9: While disp_off is 1, every COM pin shows the non-select code and every SEG pin shows the off code of the current polarity. The scan keeps advancing, so when disp_off returns to 0 the common matches uninterrupted timing.
- R10: A RAM word that is written is shown, at the latest, in the frame after the one in which it was written.
- R11: A cycle with sub_tick low does not advance the scan: selection, polarity and outputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_tick | input | 1 | Scan timebase strobe, one clk cycle per tick |
| duty_full | input | 1 | 1: 32 commons, 0: 16 commons |
| bias_hi | input | 1 | 1: 8-rung ladder (top 7), 0: 6-rung ladder (top 5) |
| disp_off | input | 1 | Blank the panel while scanning continues |
| wr_en | input | 1 | RAM write strobe |
| wr_addr | input | 9 | RAM word address (row*12 + seg/4) |
| wr_data | input | 4 | RAM write data, bit i is segment 4*word+i |
| com_lvl | output | 96 | Ladder code per common, pin c at bits 3c+2..3c |
| seg_lvl | output | 144 | Ladder code per segment, pin s at bits 3s+2..3s |

## Verification
The scan is observed with a fixed irregular RAM pattern, sampled inside commons, on the last tick before a boundary and on the first tick after it. This separates row stepping errors from frame and polarity errors and catches any shuffle of the word or bit mapping. A stalled timebase and a blanking window are checked against uninterrupted timing, which tells a held scan apart from a frozen one. A single word rewritten mid-run must show up one frame later. A mode change in the middle of a frame must leave that frame alone and then produce 16-common, 8-rung codes, and a reset straight into that mode must show the longer lead-in before the first common.

// File: rtl/lcd_scan.sv
module lcd_scan #(
  parameter int NSEG = 48,
  parameter int NCOM = 32,
  parameter int FRAME_TICKS = 512
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sub_tick,
  input  logic                              duty_full,
  input  logic                              bias_hi,
  input  logic                              disp_off,
  input  logic                              wr_en,
  input  logic [$clog2(NCOM*NSEG/4)-1:0]    wr_addr,
  input  logic [3:0]                        wr_data,
  output logic [NCOM*3-1:0]                 com_lvl,
  output logic [NSEG*3-1:0]                 seg_lvl
);
  localparam int WORDS = NSEG / 4;
  localparam int DEPTH = NCOM * WORDS;
  localparam int AW    = $clog2(DEPTH);
  localparam int RW    = $clog2(NCOM);
  localparam int TW    = $clog2(FRAME_TICKS);
  localparam int FW    = $clog2(WORDS + 1);
  localparam int HALF  = NCOM / 2;

  logic [3:0]      mem [DEPTH];
  logic            full_q, b7_q, pol, run, step, frame_end, show;
  logic [RW-1:0]   row, frow, last_row, row_nx, frow_nx;
  logic [TW-1:0]   tcnt, rt_last;
  logic [FW-1:0]   fidx;
  logic [NSEG-1:0] shadow, act;
  logic [AW-1:0]   raddr;
  logic [2:0]      top, c_sel, c_ns, s_on, s_off;

  assign last_row  = full_q ? RW'(NCOM - 1) : RW'(HALF - 1);
  assign rt_last   = full_q ? TW'(FRAME_TICKS / NCOM - 1) : TW'(FRAME_TICKS / HALF - 1);
  assign step      = sub_tick && (tcnt == rt_last);
  assign frame_end = step && (row == last_row);
  assign row_nx    = frame_end ? '0 : row + 1'b1;
  assign frow_nx   = frame_end ? RW'(1) : ((row_nx == last_row) ? '0 : row_nx + 1'b1);
  assign raddr     = AW'(frow) * AW'(WORDS) + AW'(fidx);

  always_ff @(posedge clk)
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= duty_full;
      b7_q   <= bias_hi;
      row    <= duty_full ? RW'(NCOM - 1) : RW'(HALF - 1);
      pol    <= 1'b1;
      run    <= 1'b0;
      tcnt   <= '0;
      frow   <= '0;
      fidx   <= '0;
      shadow <= '0;
      act    <= '0;
    end else begin
      if (sub_tick) tcnt <= step ? '0 : tcnt + 1'b1;
      if (step) begin
        row  <= row_nx;
        frow <= frow_nx;
        fidx <= '0;
        act  <= shadow;
        run  <= 1'b1;
        if (frame_end) begin
          pol    <= ~pol;
          full_q <= duty_full;
          b7_q   <= bias_hi;
        end
      end else if (fidx < FW'(WORDS)) begin
        shadow[4*fidx +: 4] <= mem[raddr];
        fidx <= fidx + 1'b1;
      end
    end
  end

  assign top   = b7_q ? 3'd7 : 3'd5;
  assign c_sel = pol ? 3'd0 : top;
  assign c_ns  = pol ? top - 3'd1 : 3'd1;
  assign s_on  = pol ? top : 3'd0;
  assign s_off = pol ? top - 3'd2 : 3'd2;
  assign show  = run && !disp_off;

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_lvl[c*3 +: 3] = (show && row == RW'(c)) ? c_sel : c_ns;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_lvl[s*3 +: 3] = (show && act[s]) ? s_on : s_off;
  end
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int NSEG = 48,
  parameter int NCOM = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sub_tick,
  input logic                      disp_off,
  input logic                      full_q,
  input logic                      b7_q,
  input logic                      pol,
  input logic                      run,
  input logic [$clog2(NCOM)-1:0]   row,
  input logic [NCOM*3-1:0]         com_lvl,
  input logic [NSEG*3-1:0]         seg_lvl
);
  logic [2:0] top, sel, ns, on, off;
  int nsel;
  logic upper_ns, seg_ok;

  assign top = b7_q ? 3'd7 : 3'd5;
  assign sel = pol ? 3'd0 : top;
  assign ns  = pol ? top - 3'd1 : 3'd1;
  assign on  = pol ? top : 3'd0;
  assign off = pol ? top - 3'd2 : 3'd2;

  always_comb begin
    nsel = 0;
    upper_ns = 1'b1;
    seg_ok = 1'b1;
    for (int c = 0; c < NCOM; c++) begin
      if (com_lvl[c*3 +: 3] == sel) nsel = nsel + 1;
      if (c >= NCOM/2 && com_lvl[c*3 +: 3] != ns) upper_ns = 1'b0;
    end
    for (int s = 0; s < NSEG; s++)
      if (seg_lvl[s*3 +: 3] != on && seg_lvl[s*3 +: 3] != off) seg_ok = 1'b0;
  end

  p_one_com_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !disp_off) |-> (nsel == 1));
  p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) <= (full_q ? NCOM - 1 : NCOM/2 - 1));
  p_seg_codes_r3: assert property (@(posedge clk) disable iff (!rst_n) seg_ok);
  p_flip_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (row != '0) |-> $stable(pol));
  p_unused_com_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q |-> upper_ns);
  p_mode_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row != '0) |-> ($stable(full_q) && $stable(b7_q)));
  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off || !run) |-> (nsel == 0));
  p_tick_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_tick |=> $stable(row));
endmodule

bind lcd_scan lcd_scan_chk #(.NSEG(NSEG), .NCOM(NCOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .disp_off(disp_off),
  .full_q(full_q), .b7_q(b7_q), .pol(pol), .run(run), .row(row),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_scan_tb.sv
`timescale 1ns/1ps
module lcd_scan_tb;
  localparam int NSEG = 48, NCOM = 32, WORDS = 12, DEPTH = 384;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sub_tick, duty_full, bias_hi, disp_off, wr_en;
  logic [8:0] wr_addr;
  logic [3:0] wr_data;
  logic [NCOM*3-1:0] com_lvl;
  logic [NSEG*3-1:0] seg_lvl;

  int bm [DEPTH];
  int checks = 0, errors = 0, tcount = 0;

  // tick, expected row, expected polarity (32 commons, top 5)
  localparam int VT [8][3] = '{
    '{20, 0, 0}, '{47, 1, 0}, '{48, 2, 0}, '{300, 17, 0},
    '{527, 31, 0}, '{528, 0, 1}, '{700, 10, 1}, '{1100, 3, 0}};

  lcd_scan u_dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .duty_full(duty_full),
    .bias_hi(bias_hi), .disp_off(disp_off), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  always @(posedge clk)
    if (!rst_n) tcount <= 0;
    else if (sub_tick) tcount <= tcount + 1;

  task automatic at(input int t);
    wait (tcount >= t);
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input int r, input bit p, input int a, input bit blank);
    logic [2:0] sel, ns, on, off, e, g;
    int w, bad;
    string pin;
    logic [2:0] bad_g, bad_e;
    sel = p ? 3'd0 : 3'(a);
    ns  = p ? 3'(a - 1) : 3'd1;
    on  = p ? 3'(a) : 3'd0;
    off = p ? 3'(a - 2) : 3'd2;
    bad = -1;
    pin = "";
    bad_g = '0;
    bad_e = '0;
    for (int c = 0; c < NCOM; c++) begin
      e = (!blank && c == r) ? sel : ns;
      g = com_lvl[c*3 +: 3];
      if (g != e && bad < 0) begin bad = c; pin = "com"; bad_g = g; bad_e = e; end
    end
    for (int s = 0; s < NSEG; s++) begin
      if (blank) e = off;
      else begin
        w = bm[r*WORDS + s/4];
        e = ((w >> (s % 4)) & 1) != 0 ? on : off;
      end
      g = seg_lvl[s*3 +: 3];
      if (g != e && bad < 0) begin bad = s; pin = "seg"; bad_g = g; bad_e = e; end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s tick %0d %s%0d actual %0d expected %0d", req, tcount, pin, bad, bad_g, bad_e);
    end
  endtask

  task automatic expect_at(input string req, input int t, input int base, input int rt,
                           input int nc, input bit p0, input int a);
    int k;
    at(t);
    k = (t - base) / rt;
    check_all(req, k % nc, p0 ^ bit'((k / nc) % 2), a, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sub_tick = 1; duty_full = 1; bias_hi = 0; disp_off = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      bm[i] = (i*7 + i/5 + 3) % 16;
      wr_en = 1; wr_addr = 9'(i); wr_data = 4'(bm[i]);
    end
    @(negedge clk);
    wr_en = 0;
    check_all("R1 in reset", 0, 1'b1, 5, 1'b1);
    rst_n = 1;
    at(5);  check_all("R1 lead-in", 0, 1'b1, 5, 1'b1);
    at(15); check_all("R1 lead-in end", 0, 1'b1, 5, 1'b1);

    for (int i = 0; i < 8; i++) begin
      at(VT[i][0]);
      check_all("R2 R3 R4 R5 table", VT[i][1], VT[i][2] != 0, 5, 1'b0);
    end

    at(1110);
    sub_tick = 0;
    repeat (40) @(negedge clk);
    check_all("R11 held", 4, 1'b0, 5, 1'b0);
    sub_tick = 1;
    expect_at("R11 resumed", 1130, 16, 16, 32, 1'b0, 5);

    at(1200); disp_off = 1;
    at(1250); check_all("R9 blank", 13, 1'b0, 5, 1'b1);
    at(1300); disp_off = 0;
    expect_at("R9 scan kept", 1301, 16, 16, 32, 1'b0, 5);

    at(1310);
    bm[41] = (~bm[41]) & 15;
    wr_en = 1; wr_addr = 9'd41; wr_data = 4'(bm[41]);
    @(negedge clk);
    wr_en = 0;
    expect_at("R10 rewrite", 1605, 16, 16, 32, 1'b0, 5);

    at(1700); duty_full = 0; bias_hi = 1;
    expect_at("R8 frame unchanged", 1800, 16, 16, 32, 1'b0, 5);
    expect_at("R6 R7 new frame", 2070, 2064, 32, 16, 1'b0, 7);
    expect_at("R6 last common", 2549, 2064, 32, 16, 1'b0, 7);
    expect_at("R4 next frame", 2579, 2064, 32, 16, 1'b0, 7);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check_all("R1 reset half", 0, 1'b1, 7, 1'b1);
    rst_n = 1;
    at(31); check_all("R1 half lead-in", 0, 1'b1, 7, 1'b1);
    expect_at("R2 R6 first common", 32, 32, 32, 16, 1'b0, 7);
    expect_at("R2 second common", 95, 32, 32, 16, 1'b0, 7);
    expect_at("R4 half flip", 544, 32, 32, 16, 1'b0, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule